// File: doc/BRIEF.md
# Board Control Register Bank with Interrupt Aggregation

This block is a bank of 32-bit registers on a simple single-cycle register bus. It merges sixteen level-sensitive external interrupt lines into one parent interrupt. An enable register selects which lines may raise a request. A pending register captures requests, and software can set or clear its bits.

Eight plain registers give software storage for LEDs, switches and miscellaneous board functions. Two card-socket status registers hold a ready bit and an active-low card-detect bit. The card-detect bit follows a dedicated interrupt line. Software may change only the five lowest control bits of a socket register.

The bus uses a word address, which is the byte offset divided by four. A transfer occurs on each cycle where `bus_valid` is high. Read data appears on `bus_rdata` in the cycle after the read, and is zero in the cycle after any non-read.

Top module: `board_ctl_regs`

## Requirements
- R1: `irq_out` is a register. Its value in each cycle is the OR-reduction of (pending AND enable) as those registers stood in the previous cycle.
- R2: When `irq_in[n]` is high and enable bit n is set, pending bit n is set at the next edge. It stays set after the input falls, until software writes it to zero.
- R3: If an input is high while its enable bit is clear, nothing is latched. Setting the enable bit later, after the input has fallen, does not set the pending bit.
- R4: A write to the enable register (byte offset 0xC0) or to the pending register (byte offset 0xD0) stores the write data ANDed with 0x000FEEFF. The pending register is replaced outright, so writing a 0 bit clears that bit.
- R5: If a hardware set and a software write of the pending register fall in the same cycle, the result is the masked write value ORed with the enabled inputs.
- R6: The eight plain registers store and return all 32 bits. Their byte offsets are 0x10, 0x14, 0x40, 0x60, 0x80, 0x84, 0x88 and 0x90. Read data is returned in the cycle after the read.
- R7: A write to socket register 0 (byte offset 0xE0) or socket register 1 (byte offset 0xE4) changes only bits [4:0].
- R8: Bit 5 of socket 0 is the inverse of `irq_in[9]`, and bit 5 of socket 1 is the inverse of `irq_in[13]`, each registered one cycle.
- R9: After reset, both socket registers read 0x00000420 (bit 10 and bit 5 set). Every other register reads 0, and `irq_out` is low.
- R10: A read from an undecoded word address returns 0. A write to one changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Transfer strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Word address (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the read |
| irq_in | input | 16 | External level interrupt lines |
| irq_out | output | 1 | Aggregated parent interrupt |

## Verification
Two functions can act on the pending register in the same clock edge: a software write and the hardware latch of an enabled input. The bench provokes this collision by raising two enabled inputs in the same cycle that it writes the pending register. That write clears one of the rising bits and sets one bit that is settable only by software. The pending value read back afterwards must equal the masked write value ORed with the raised inputs. Only this result shows that the write was taken first and the hardware event was not lost.

// File: rtl/board_ctl_regs.sv
module board_ctl_regs #(
  parameter int AW = 6,
  parameter int DW = 32,
  parameter int NIRQ = 16,
  parameter logic [31:0] IRQ_KEEP = 32'h000F_EEFF,
  parameter int SOCK_WR_BITS = 5,
  parameter int CD_BIT = 5,
  parameter int RDY_BIT = 10,
  parameter int CD0_SRC = 9,
  parameter int CD1_SRC = 13
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_valid,
  input  logic            bus_write,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic [NIRQ-1:0] irq_in,
  output logic            irq_out
);
  localparam int NPLAIN = 8;
  localparam int PW = $clog2(NPLAIN);
  localparam logic [AW-1:0] A_LED1  = AW'(8'h10 >> 2);
  localparam logic [AW-1:0] A_LED2  = AW'(8'h14 >> 2);
  localparam logic [AW-1:0] A_LEDC  = AW'(8'h40 >> 2);
  localparam logic [AW-1:0] A_SW    = AW'(8'h60 >> 2);
  localparam logic [AW-1:0] A_MISC1 = AW'(8'h80 >> 2);
  localparam logic [AW-1:0] A_MISC2 = AW'(8'h84 >> 2);
  localparam logic [AW-1:0] A_MISC3 = AW'(8'h88 >> 2);
  localparam logic [AW-1:0] A_MISCR = AW'(8'h90 >> 2);
  localparam logic [AW-1:0] A_EN    = AW'(8'hC0 >> 2);
  localparam logic [AW-1:0] A_PEND  = AW'(8'hD0 >> 2);
  localparam logic [AW-1:0] A_SOCK0 = AW'(8'hE0 >> 2);
  localparam logic [AW-1:0] A_SOCK1 = AW'(8'hE4 >> 2);
  localparam logic [DW-1:0] KEEP = DW'(IRQ_KEEP);
  localparam logic [DW-1:0] SOCK_RST = (DW'(1) << RDY_BIT) | (DW'(1) << CD_BIT);

  logic [DW-1:0] plain_q [NPLAIN];
  logic [DW-1:0] en_q, pend_q, sock0_q, sock1_q, rd_mux, hw_set;
  logic [PW-1:0] plain_idx;
  logic          plain_hit;

  wire wr_en = bus_valid & bus_write;
  wire rd_en = bus_valid & ~bus_write;
  assign hw_set = DW'(irq_in) & en_q;

  always_comb begin
    plain_hit = 1'b1;
    plain_idx = '0;
    case (bus_addr)
      A_LED1:  plain_idx = PW'(0);
      A_LED2:  plain_idx = PW'(1);
      A_LEDC:  plain_idx = PW'(2);
      A_SW:    plain_idx = PW'(3);
      A_MISC1: plain_idx = PW'(4);
      A_MISC2: plain_idx = PW'(5);
      A_MISC3: plain_idx = PW'(6);
      A_MISCR: plain_idx = PW'(7);
      default: plain_hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NPLAIN; i++) plain_q[i] <= '0;
    end else if (wr_en && plain_hit) begin
      plain_q[plain_idx] <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= '0;
      pend_q  <= '0;
      irq_out <= 1'b0;
    end else begin
      if (wr_en && bus_addr == A_EN) en_q <= bus_wdata & KEEP;
      pend_q  <= ((wr_en && bus_addr == A_PEND) ? (bus_wdata & KEEP) : pend_q) | hw_set;
      irq_out <= |(pend_q & en_q);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sock0_q <= SOCK_RST;
      sock1_q <= SOCK_RST;
    end else begin
      if (wr_en && bus_addr == A_SOCK0) sock0_q[SOCK_WR_BITS-1:0] <= bus_wdata[SOCK_WR_BITS-1:0];
      if (wr_en && bus_addr == A_SOCK1) sock1_q[SOCK_WR_BITS-1:0] <= bus_wdata[SOCK_WR_BITS-1:0];
      sock0_q[CD_BIT] <= ~irq_in[CD0_SRC];
      sock1_q[CD_BIT] <= ~irq_in[CD1_SRC];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (plain_hit) rd_mux = plain_q[plain_idx];
    else case (bus_addr)
      A_EN:    rd_mux = en_q;
      A_PEND:  rd_mux = pend_q;
      A_SOCK0: rd_mux = sock0_q;
      A_SOCK1: rd_mux = sock1_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= rd_en ? rd_mux : '0;
  end

  // R1
  irq_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == $past(|(pend_q & en_q)));

  // R2
  pend_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    |hw_set |=> ((pend_q & $past(hw_set)) == $past(hw_set)));

  // R4
  en_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && bus_addr == A_EN) |=> en_q == ($past(bus_wdata) & KEEP));

  // R7
  sock_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (sock0_q[DW-1:CD_BIT+1] == $past(sock0_q[DW-1:CD_BIT+1]) &&
              sock1_q[DW-1:CD_BIT+1] == $past(sock1_q[DW-1:CD_BIT+1])));

  // R8
  card_detect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (sock0_q[CD_BIT] == !$past(irq_in[CD0_SRC]) &&
              sock1_q[CD_BIT] == !$past(irq_in[CD1_SRC])));

  // R10
  undecoded_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !plain_hit && bus_addr != A_EN && bus_addr != A_PEND &&
     bus_addr != A_SOCK0 && bus_addr != A_SOCK1) |=> bus_rdata == '0);
endmodule

// File: tb/board_ctl_regs_test.sv
module board_ctl_regs_test;
  logic clk = 1'b0, rst_n = 1'b0, bus_valid = 1'b0, bus_write = 1'b0;
  logic [5:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [15:0] irq_in = '0;
  logic irq_out;
  int checks = 0, fails = 0;

  localparam logic [31:0] KEEP = 32'h000F_EEFF;

  board_ctl_regs uut (.clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_in(irq_in), .irq_out(irq_out));

  always #2.5 clk = ~clk;

  function automatic int kind(input logic [5:0] a);
    case (a)
      6'h04, 6'h05, 6'h10, 6'h18, 6'h20, 6'h21, 6'h22, 6'h24: return 1;
      6'h30, 6'h34: return 2;
      6'h38, 6'h39: return 3;
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] pat(input logic [5:0] a);
    return 32'h9E37_79B9 ^ ({26'd0, a} * 32'h0103_0507);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); bus_valid = 1; bus_write = 0; bus_addr = a;
    @(negedge clk); d = bus_rdata; bus_valid = 0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #500000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] d, e;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R9 reset values across the whole map
    chk("R9 irq_out", {31'd0, irq_out}, 0);
    for (int a = 0; a < 64; a++) begin
      rd(6'(a), d);
      chk("R9 reset", d, kind(6'(a)) == 3 ? 32'h420 : 32'h0);
    end
    // R6 R4 R7 R10 full sweep of writes, then reads
    for (int a = 0; a < 64; a++) wr(6'(a), pat(6'(a)));
    for (int a = 0; a < 64; a++) begin
      rd(6'(a), d);
      case (kind(6'(a)))
        1: chk("R6 plain", d, pat(6'(a)));
        2: chk("R4 masked", d, pat(6'(a)) & KEEP);
        3: chk("R7 socket", d, 32'h420 | (pat(6'(a)) & 32'h1F));
        default: chk("R10 undecoded", d, 0);
      endcase
    end
    // R6 all-ones and all-zeros pattern on one plain register
    wr(6'h24, 32'hFFFF_FFFF); rd(6'h24, d); chk("R6 ones", d, 32'hFFFF_FFFF);
    wr(6'h24, 32'h0); rd(6'h24, d); chk("R6 zeros", d, 0);
    // R4 pending replaced outright
    wr(6'h34, 32'hFFFF_FFFF); wr(6'h34, 32'h0000_0100);
    rd(6'h34, d); chk("R4 replace", d, 0);
    // R1 latency and enable gating
    wr(6'h30, 32'h0); wr(6'h34, 32'h0);
    @(negedge clk);
    wr(6'h34, 32'h1);
    chk("R1 not yet", {31'd0, irq_out}, 0);
    @(negedge clk); chk("R1 asserted", {31'd0, irq_out}, 0);
    wr(6'h30, 32'h1);
    chk("R1 enable pending", {31'd0, irq_out}, 0);
    @(negedge clk); chk("R1 rises", {31'd0, irq_out}, 1);
    wr(6'h30, 32'h0);
    chk("R1 held", {31'd0, irq_out}, 1);
    @(negedge clk); chk("R1 falls", {31'd0, irq_out}, 0);
    // R2 latch and stick, each input
    wr(6'h30, KEEP);
    for (int n = 0; n < 16; n++) begin
      wr(6'h34, 32'h0);
      @(negedge clk); irq_in = 16'(1 << n);
      @(negedge clk); irq_in = '0;
      rd(6'h34, d);
      chk("R2 sticky", d, (32'(1) << n) & KEEP);
      wr(6'h34, 32'h0); rd(6'h34, d);
      chk("R2 cleared", d, 0);
    end
    // R3 disabled input does not latch, even after enabling later
    wr(6'h30, 32'h0); wr(6'h34, 32'h0);
    @(negedge clk); irq_in = 16'h0001;
    @(negedge clk); @(negedge clk); irq_in = '0;
    wr(6'h30, 32'h1);
    rd(6'h34, d); chk("R3 no latch", d, 0);
    chk("R3 irq_out", {31'd0, irq_out}, 0);
    // R5 collision of hardware set and software write
    wr(6'h30, KEEP); wr(6'h34, 32'h0);
    @(negedge clk);
    irq_in = 16'h0012; bus_valid = 1; bus_write = 1; bus_addr = 6'h34; bus_wdata = 32'h0002_0101;
    @(negedge clk);
    bus_valid = 0; bus_write = 0; irq_in = '0;
    rd(6'h34, d); e = (32'h0002_0101 & KEEP) | 32'h12;
    chk("R5 collision", d, e);
    // R8 card detect mirror
    wr(6'h30, 32'h0); wr(6'h34, 32'h0);
    wr(6'h38, 32'h0); wr(6'h39, 32'h1F);
    @(negedge clk); irq_in = 16'h0200;
    rd(6'h38, d); chk("R8 sock0 low", d, 32'h400);
    rd(6'h39, d); chk("R8 sock1 idle", d, 32'h43F);
    irq_in = 16'h2000;
    rd(6'h38, d); chk("R8 sock0 back", d, 32'h420);
    rd(6'h39, d); chk("R8 sock1 low", d, 32'h41F);
    // R7 write cannot touch the card-detect or ready bits
    wr(6'h39, 32'hFFFF_FFE0); rd(6'h39, d); chk("R7 upper kept", d, 32'h400);
    irq_in = '0;
    rd(6'h39, d); chk("R8 sock1 release", d, 32'h420);
    summary();
  end
endmodule